// File: doc/BRIEF.md
# PCI Configuration Header Responder

This block answers byte-wide configuration reads and writes for a single display function on a PCI bus. It returns a fixed identity (vendor, device, status, class, interrupt pin) and holds the few writable fields the function needs. These are a command byte, the top byte of one framebuffer base address register, an expansion ROM base and enable, and an interrupt line byte.

From the stored fields it drives the decode enables for the rest of the display function. Two I/O enables cover the VGA register range and the mode-register ports. Memory enables cover the legacy video window, a 16 MiB framebuffer window and its base, a second alias copy of that window at a fixed address, and a 64 KiB ROM window with its base. Reads are combinational on the function number and byte address. Writes take effect at the next clock edge and only for function 0.

Top module: `pci_cfg_hdr_resp`

## Requirements
- R1: For function 0, bytes 0x00, 0x01, 0x02, 0x03 read 0x34, 0x12, 0x11, 0x11. Byte 0x06 reads 0x80, byte 0x07 reads 0x02, byte 0x0B reads 0x03 and byte 0x3D reads 0x01, whatever was written.
- R2: Byte 0x04 (command) stores the full written byte and reads back as (stored & 0xE3) | 0x80; it reads 0x80 after reset.
- R3: Of the framebuffer base register, only byte 0x13 is writable and reads back as written. Bytes 0x10 to 0x12 read 0x00. Byte 0x17 reads 0xE0 when byte 0x13 is nonzero and 0x00 otherwise.
- R4: The framebuffer window is enabled exactly when command bit 1 is set and byte 0x13 is nonzero, and its base is byte 0x13 shifted left by 24.
- R5: The alias window is enabled exactly when the framebuffer window is enabled and byte 0x13 differs from 0xE0.
- R6: Command bit 0 enables both the VGA I/O range and the mode-register ports.
- R7: Command bit 1 enables the legacy memory window.
- R8: Byte 0x30 bit 0 is the ROM enable and reads back alone in bit 0. Byte 0x32 stores the written value AND 0xFC. Byte 0x33 stores the full value. The ROM window enable follows byte 0x30 bit 0, and its base is {byte 0x33, byte 0x32} shifted left by 16.
- R9: Byte 0x3C is a read/write interrupt line register.
- R10: Any read with a function number other than 0 returns 0xFF, and writes to such functions change nothing.
- R11: Offsets not named above read 0x00 and ignore writes.
- R12: After reset every writable field is 0 and every decode enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wr_en | input | 1 | Write strobe, one byte per cycle |
| cfg_wr_data | input | 8 | Write data |
| cfg_rd_data | output | 8 | Read data for cfg_func/cfg_addr |
| io_vga_en | output | 1 | VGA I/O range decode enable |
| io_mode_en | output | 1 | Mode-register port decode enable |
| mem_legacy_en | output | 1 | Legacy memory window enable |
| fb_win_en | output | 1 | Framebuffer window enable |
| fb_win_base | output | 32 | Framebuffer window base address |
| alias_win_en | output | 1 | Alias framebuffer window enable |
| rom_win_en | output | 1 | Expansion ROM window enable |
| rom_win_base | output | 32 | Expansion ROM window base address |

## Verification
The bench aims at the cases where a plausible design goes wrong. The base byte set to 0xE0 must keep the framebuffer window but drop the alias; a design that compared against the wrong value would open a duplicate window over the primary one. The command read mask must drop bits 2 to 4 and force bit 7, while the ROM low byte must lose its two low bits; a missing mask shows up as a wrong read value. Writes addressed to a non-zero function and to unlisted offsets are followed by reads through function 0, so a decoder that ignored the function number or aliased offsets would corrupt the command byte or return nonzero data.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
   // Byte offsets inside the configuration header
   localparam logic [7:0] OFS_ID0      = 8'h00;
   localparam logic [7:0] OFS_ID1      = 8'h01;
   localparam logic [7:0] OFS_ID2      = 8'h02;
   localparam logic [7:0] OFS_ID3      = 8'h03;
   localparam logic [7:0] OFS_CMD      = 8'h04;
   localparam logic [7:0] OFS_STAT_LO  = 8'h06;
   localparam logic [7:0] OFS_STAT_HI  = 8'h07;
   localparam logic [7:0] OFS_CLASS    = 8'h0B;
   localparam logic [7:0] OFS_FB_TOP   = 8'h13;
   localparam logic [7:0] OFS_FB_SIZE  = 8'h17;
   localparam logic [7:0] OFS_ROM_CTL  = 8'h30;
   localparam logic [7:0] OFS_ROM_LO   = 8'h32;
   localparam logic [7:0] OFS_ROM_HI   = 8'h33;
   localparam logic [7:0] OFS_IRQ_LINE = 8'h3C;
   localparam logic [7:0] OFS_IRQ_PIN  = 8'h3D;

   localparam logic [7:0] CMD_RD_MASK  = 8'hE3;
   localparam logic [7:0] CMD_RD_FORCE = 8'h80;
   localparam logic [7:0] ROM_LO_MASK  = 8'hFC;
   localparam logic [7:0] NO_FUNC_DATA = 8'hFF;

   localparam int CMD_IO_BIT  = 0;
   localparam int CMD_MEM_BIT = 1;

   // Snapshot of all writable header state
   typedef struct packed {
      logic [7:0] cmd;
      logic [7:0] fb_top;
      logic       rom_on;
      logic [7:0] rom_lo;
      logic [7:0] rom_hi;
      logic [7:0] irq_line;
   } cfg_state_t;
endpackage

// File: rtl/pci_cfg_regs.sv
module pci_cfg_regs
   import pci_cfg_pkg::*;
#(
   parameter int FUNC_W = 3,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] func,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output cfg_state_t        st
);
   localparam logic [FUNC_W-1:0] FUNC_ZERO = '0;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("pci_cfg_regs: DATA_W must be 8");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("pci_cfg_regs: ADDR_W must be at least 8");
   end

   cfg_state_t st_q;
   logic       wr_ok;

   assign wr_ok = wr_en && (func == FUNC_ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (wr_ok) begin
         case (addr)
            ADDR_W'(OFS_CMD):      st_q.cmd      <= wr_data[7:0];
            ADDR_W'(OFS_FB_TOP):   st_q.fb_top   <= wr_data[7:0];
            ADDR_W'(OFS_ROM_CTL):  st_q.rom_on   <= wr_data[0];
            ADDR_W'(OFS_ROM_LO):   st_q.rom_lo   <= wr_data[7:0] & ROM_LO_MASK;
            ADDR_W'(OFS_ROM_HI):   st_q.rom_hi   <= wr_data[7:0];
            ADDR_W'(OFS_IRQ_LINE): st_q.irq_line <= wr_data[7:0];
            default: ;
         endcase
      end
   end

   assign st = st_q;

   AST_FOREIGN_FUNC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && func != FUNC_ZERO) |=> $stable(st_q)) else $error("foreign write changed state"); // R10

   AST_BAR_TOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && addr == ADDR_W'(OFS_FB_TOP)) |=> (st_q.fb_top == $past(wr_data[7:0]))) else $error("bar capture"); // R3

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && addr == ADDR_W'(OFS_CMD)) |=> $stable(st_q.cmd)) else $error("cmd changed"); // R2
endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
   import pci_cfg_pkg::*;
#(
   parameter int          FUNC_W    = 3,
   parameter int          ADDR_W    = 8,
   parameter logic [15:0] VENDOR_ID = 16'h1234,
   parameter logic [15:0] DEVICE_ID = 16'h1111,
   parameter logic [7:0]  CLASS_TOP = 8'h03,
   parameter logic [7:0]  FB_SIZE_B = 8'hE0
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [ADDR_W-1:0] addr,
   input  cfg_state_t        st,
   output logic [7:0]        rd_data
);
   localparam logic [FUNC_W-1:0] FUNC_ZERO = '0;

   logic [7:0] hdr_byte;

   always_comb begin
      case (addr)
         ADDR_W'(OFS_ID0):      hdr_byte = VENDOR_ID[7:0];
         ADDR_W'(OFS_ID1):      hdr_byte = VENDOR_ID[15:8];
         ADDR_W'(OFS_ID2):      hdr_byte = DEVICE_ID[7:0];
         ADDR_W'(OFS_ID3):      hdr_byte = DEVICE_ID[15:8];
         ADDR_W'(OFS_CMD):      hdr_byte = (st.cmd & CMD_RD_MASK) | CMD_RD_FORCE;
         ADDR_W'(OFS_STAT_LO):  hdr_byte = 8'h80;
         ADDR_W'(OFS_STAT_HI):  hdr_byte = 8'h02;
         ADDR_W'(OFS_CLASS):    hdr_byte = CLASS_TOP;
         ADDR_W'(OFS_FB_TOP):   hdr_byte = st.fb_top;
         ADDR_W'(OFS_FB_SIZE):  hdr_byte = (st.fb_top != 8'h00) ? FB_SIZE_B : 8'h00;
         ADDR_W'(OFS_ROM_CTL):  hdr_byte = {7'b0, st.rom_on};
         ADDR_W'(OFS_ROM_LO):   hdr_byte = st.rom_lo;
         ADDR_W'(OFS_ROM_HI):   hdr_byte = st.rom_hi;
         ADDR_W'(OFS_IRQ_LINE): hdr_byte = st.irq_line;
         ADDR_W'(OFS_IRQ_PIN):  hdr_byte = 8'h01;
         default:               hdr_byte = 8'h00;
      endcase
   end

   assign rd_data = (func == FUNC_ZERO) ? hdr_byte : NO_FUNC_DATA;
endmodule

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
   import pci_cfg_pkg::*;
#(
   parameter int         AW         = 32,
   parameter int         FB_LOG2    = 24,
   parameter int         ROM_LOG2   = 16,
   parameter bit         ALIAS_EN   = 1'b1,
   parameter logic [7:0] ALIAS_TOP  = 8'hE0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cfg_state_t    st,
   output logic          io_vga_en,
   output logic          io_mode_en,
   output logic          mem_legacy_en,
   output logic          fb_win_en,
   output logic [AW-1:0] fb_win_base,
   output logic          alias_win_en,
   output logic          rom_win_en,
   output logic [AW-1:0] rom_win_base
);
   localparam int FB_TOP_W  = AW - FB_LOG2;
   localparam int ROM_TOP_W = AW - ROM_LOG2;

   if (FB_TOP_W != 8) begin : g_bad_fb
      $error("pci_cfg_decode: AW - FB_LOG2 must equal the 8-bit base byte");
   end
   if (ROM_TOP_W != 16) begin : g_bad_rom
      $error("pci_cfg_decode: AW - ROM_LOG2 must equal 16");
   end

   logic io_on, mem_on, fb_on;

   assign io_on  = st.cmd[CMD_IO_BIT];
   assign mem_on = st.cmd[CMD_MEM_BIT];
   assign fb_on  = mem_on && (st.fb_top != 8'h00);

   assign io_vga_en     = io_on;
   assign io_mode_en    = io_on;
   assign mem_legacy_en = mem_on;
   assign fb_win_en     = fb_on;
   assign fb_win_base   = {st.fb_top, {FB_LOG2{1'b0}}};
   assign rom_win_en    = st.rom_on;
   assign rom_win_base  = {st.rom_hi, st.rom_lo, {ROM_LOG2{1'b0}}};

   if (ALIAS_EN) begin : g_alias
      assign alias_win_en = fb_on && (st.fb_top != ALIAS_TOP);
   end else begin : g_no_alias
      assign alias_win_en = 1'b0;
   end

   AST_ALIAS_NEEDS_FB: assert property (@(posedge clk) disable iff (!rst_n)
      alias_win_en |-> fb_win_en) else $error("alias without fb"); // R5

   AST_FB_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      fb_win_en |-> mem_legacy_en) else $error("fb without mem decode"); // R4

   AST_ROM_BASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rom_win_base[ROM_LOG2+1:ROM_LOG2] == 2'b00) else $error("rom base misaligned"); // R8
endmodule

// File: rtl/pci_cfg_hdr_resp.sv
module pci_cfg_hdr_resp
   import pci_cfg_pkg::*;
#(
   parameter int          FUNC_W    = 3,
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int          AW        = 32,
   parameter int          FB_LOG2   = 24,
   parameter int          ROM_LOG2  = 16,
   parameter bit          ALIAS_EN  = 1'b1,
   parameter logic [7:0]  ALIAS_TOP = 8'hE0,
   parameter logic [15:0] VENDOR_ID = 16'h1234,
   parameter logic [15:0] DEVICE_ID = 16'h1111,
   parameter logic [7:0]  CLASS_TOP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUNC_W-1:0] cfg_func,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_wr_en,
   input  logic [DATA_W-1:0] cfg_wr_data,
   output logic [DATA_W-1:0] cfg_rd_data,
   output logic              io_vga_en,
   output logic              io_mode_en,
   output logic              mem_legacy_en,
   output logic              fb_win_en,
   output logic [AW-1:0]     fb_win_base,
   output logic              alias_win_en,
   output logic              rom_win_en,
   output logic [AW-1:0]     rom_win_base
);
   // Size bits reported for a window of 2**FB_LOG2 bytes in the top byte
   localparam logic [7:0] FB_SIZE_B = 8'((9'h100 - (9'h1 << (FB_LOG2 - 24 + 5))) & 9'h0FF) | 8'hE0;

   cfg_state_t st;
   logic [7:0] rd_byte;

   pci_cfg_regs #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .func(cfg_func), .addr(cfg_addr),
      .wr_en(cfg_wr_en), .wr_data(cfg_wr_data), .st(st)
   );

   pci_cfg_rdmux #(
      .FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .VENDOR_ID(VENDOR_ID),
      .DEVICE_ID(DEVICE_ID), .CLASS_TOP(CLASS_TOP), .FB_SIZE_B(FB_SIZE_B)
   ) rdmux_i (
      .func(cfg_func), .addr(cfg_addr), .st(st), .rd_data(rd_byte)
   );

   assign cfg_rd_data = DATA_W'(rd_byte);

   pci_cfg_decode #(
      .AW(AW), .FB_LOG2(FB_LOG2), .ROM_LOG2(ROM_LOG2),
      .ALIAS_EN(ALIAS_EN), .ALIAS_TOP(ALIAS_TOP)
   ) dec_i (
      .clk(clk), .rst_n(rst_n), .st(st),
      .io_vga_en(io_vga_en), .io_mode_en(io_mode_en),
      .mem_legacy_en(mem_legacy_en), .fb_win_en(fb_win_en),
      .fb_win_base(fb_win_base), .alias_win_en(alias_win_en),
      .rom_win_en(rom_win_en), .rom_win_base(rom_win_base)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !(io_vga_en || mem_legacy_en || fb_win_en || alias_win_en || rom_win_en))
      else $error("decode active out of reset"); // R12
endmodule

// File: tb/pci_cfg_hdr_resp_tb_top.sv
module pci_cfg_hdr_resp_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_func = '0;
   logic [7:0]  cfg_addr = '0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_data = '0;
   logic [7:0]  cfg_rd_data;
   logic        io_vga_en, io_mode_en, mem_legacy_en, fb_win_en, alias_win_en, rom_win_en;
   logic [31:0] fb_win_base, rom_win_base;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // kind 0: read data, 1: enable flags {io_vga,io_mode,mem,fb,alias,rom}, 2: fb base, 3: rom base
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   pci_cfg_hdr_resp dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
      .io_vga_en(io_vga_en), .io_mode_en(io_mode_en), .mem_legacy_en(mem_legacy_en),
      .fb_win_en(fb_win_en), .fb_win_base(fb_win_base), .alias_win_en(alias_win_en),
      .rom_win_en(rom_win_en), .rom_win_base(rom_win_base)
   );

   task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wr_data = d; cfg_wr_en = 1'b1;
   endtask

   task automatic expect_item(input int k, input logic [2:0] f, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      cfg_func = f; cfg_addr = a; cfg_wr_en = 1'b0;
      it.kind = k; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      expect_item(0, 3'd0, a, {24'h0, e}, tag);
   endtask

   // Monitor: compares one expected item per cycle, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() != 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               0: act = {24'h0, cfg_rd_data};
               1: act = {26'h0, io_vga_en, io_mode_en, mem_legacy_en, fb_win_en, alias_win_en, rom_win_en};
               2: act = fb_win_base;
               default: act = rom_win_base;
            endcase
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd(8'h04, 8'h80, "R12 cmd after reset");
      expect_item(1, 3'd0, 8'h00, 32'h0, "R12 enables low after reset");
      rd(8'h13, 8'h00, "R12 bar after reset");
      rd(8'h17, 8'h00, "R3 size byte with zero bar");
      rd(8'h30, 8'h00, "R12 rom enable after reset");

      // R1 identity
      rd(8'h00, 8'h34, "R1 byte 00");
      rd(8'h01, 8'h12, "R1 byte 01");
      rd(8'h02, 8'h11, "R1 byte 02");
      rd(8'h03, 8'h11, "R1 byte 03");
      rd(8'h06, 8'h80, "R1 byte 06");
      rd(8'h07, 8'h02, "R1 byte 07");
      rd(8'h0B, 8'h03, "R1 byte 0B");
      rd(8'h3D, 8'h01, "R1 byte 3D");
      wr(3'd0, 8'h00, 8'h55);
      rd(8'h00, 8'h34, "R1 byte 00 after write");

      // R2 command mask, R6/R7 enables, R4 no fb with zero bar
      wr(3'd0, 8'h04, 8'hFF);
      rd(8'h04, 8'hE3, "R2 command masked read");
      expect_item(1, 3'd0, 8'h00, 32'h38, "R6 R7 R4 enables with zero bar");

      // R3 low bar bytes not writable
      wr(3'd0, 8'h10, 8'hAA);
      wr(3'd0, 8'h11, 8'hAA);
      wr(3'd0, 8'h12, 8'hAA);
      rd(8'h10, 8'h00, "R3 byte 10");
      rd(8'h11, 8'h00, "R3 byte 11");
      rd(8'h12, 8'h00, "R3 byte 12");

      // R4/R5 framebuffer and alias
      wr(3'd0, 8'h13, 8'hC0);
      rd(8'h13, 8'hC0, "R3 byte 13 readback");
      rd(8'h17, 8'hE0, "R3 size byte nonzero bar");
      expect_item(1, 3'd0, 8'h00, 32'h3E, "R4 R5 fb and alias on");
      expect_item(2, 3'd0, 8'h00, 32'hC000_0000, "R4 fb base");
      wr(3'd0, 8'h13, 8'hE0);
      expect_item(1, 3'd0, 8'h00, 32'h3C, "R5 alias off at E0");
      expect_item(2, 3'd0, 8'h00, 32'hE000_0000, "R4 fb base E0");

      // R6 io off, mem on
      wr(3'd0, 8'h04, 8'h02);
      expect_item(1, 3'd0, 8'h00, 32'h0C, "R6 io decode off");
      // R7 mem off kills fb and alias
      wr(3'd0, 8'h13, 8'h40);
      wr(3'd0, 8'h04, 8'h01);
      expect_item(1, 3'd0, 8'h00, 32'h30, "R7 R4 mem decode off");
      rd(8'h04, 8'h81, "R2 command io only");

      // R8 rom
      wr(3'd0, 8'h32, 8'hFF);
      wr(3'd0, 8'h33, 8'hAB);
      rd(8'h32, 8'hFC, "R8 rom low masked");
      rd(8'h33, 8'hAB, "R8 rom high");
      expect_item(3, 3'd0, 8'h00, 32'hABFC_0000, "R8 rom base");
      expect_item(1, 3'd0, 8'h00, 32'h30, "R8 rom window off");
      wr(3'd0, 8'h30, 8'hFF);
      rd(8'h30, 8'h01, "R8 rom enable readback");
      expect_item(1, 3'd0, 8'h00, 32'h31, "R8 rom window on");

      // R9 interrupt line
      wr(3'd0, 8'h3C, 8'h5A);
      rd(8'h3C, 8'h5A, "R9 irq line");

      // R10 other functions
      expect_item(0, 3'd1, 8'h00, 32'hFF, "R10 func1 byte 00");
      expect_item(0, 3'd7, 8'h04, 32'hFF, "R10 func7 byte 04");
      wr(3'd1, 8'h04, 8'h00);
      wr(3'd2, 8'h3C, 8'h00);
      rd(8'h04, 8'h81, "R10 command kept after foreign write");
      rd(8'h3C, 8'h5A, "R10 irq kept after foreign write");

      // R11 unlisted offsets
      wr(3'd0, 8'h40, 8'h77);
      rd(8'h40, 8'h00, "R11 unlisted offset 40");
      rd(8'h08, 8'h00, "R11 unlisted offset 08");
      expect_item(1, 3'd0, 8'h00, 32'h31, "R11 enables unchanged");

      @(negedge clk);
      cfg_wr_en = 1'b0;
      while (sb_q.size() != 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule